// File: doc/BRIEF.md
# Overlapping 1101 Sequence Recognizer

This block watches a serial stream of bits, one bit per clock when the qualifier `bit_valid` is high. It raises `match_out` in the same cycle that the closing 1 of the pattern 1101 arrives, where the pattern is read oldest bit first. The flag is a Mealy output: it depends on the registered progress state and on the bit on the input in that cycle, so no extra cycle of latency is added.

Matches may share bits. The closing 1 of one match is kept as the opening 1 of the next candidate, so the stream 1101101 reports two hits. Cycles with `bit_valid` low are skipped entirely: progress is frozen and the flag stays low. A synchronous reset discards all history.

The state register can be built with a dense two-bit code or with a one-hot code. A parameter selects the code, and the behaviour at the ports is the same for both.

Top module: `seq1101_watch`

## Requirements
- R1: While `rst` is high at a rising edge, `match_out` is 0. After that edge no earlier bit counts toward a match, so the bits 1,1,0,1 that follow reset give a hit on the fourth bit.
- R2: `match_out` is 1 in a cycle exactly when `bit_valid`=1 and `bit_in`=1 and the three previous valid bits, oldest first, were 1,1,0. The output changes in the same cycle as the inputs, with no register delay.
- R3: Matches overlap. After a hit, the closing 1 counts as a first 1, so the valid stream 1,1,0,1,1,0,1 gives hits on bits 4 and 7.
- R4: A cycle with `bit_valid`=0 leaves the match progress unchanged. For example 1,1,0, then an idle cycle, then 1 still gives a hit.
- R5: When `bit_valid`=0, `match_out` is 0 whatever the values of `bit_in` and of the state.
- R6: A run of more than two 1s keeps the progress at "11 seen", so the stream 1,1,1,0,1 gives a hit on its last bit.
- R7: A 0 that arrives after 1,1,0 drops all progress, so 1,1,0,0,1 gives no hit.
- R8: A 0 that arrives after a single 1 drops all progress, so 1,0,1 gives no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial data bit |
| match_out | output | 1 | High in the cycle that completes 1101 |

## Verification
A corrupted progress state shows at `match_out` no later than the fourth valid bit that follows it. It appears either as a missing hit at the point where the stream completes 1101 or as a hit that the last three bits do not support. A wrong transition taken on an idle cycle shows up on the next valid 1 that should or should not complete a match. The bench therefore compares the flag on every cycle against a three-bit history of valid bits. It does this over hand-built streams and over a long pseudo-random stream that mixes idle cycles with data.

// File: rtl/seq1101_pkg.sv
package seq1101_pkg;

    // Progress through the pattern; the order is relied on by the one-hot code
    typedef enum logic [1:0] {
        ST_NONE  = 2'd0,   // nothing useful seen
        ST_ONE   = 2'd1,   // last valid bit was 1
        ST_TWO   = 2'd2,   // last two valid bits were 11
        ST_THREE = 2'd3    // last three valid bits were 110
    } prog_e;

    localparam int NUM_STATES = 4;
    localparam int DENSE_W    = 2;

endpackage

// File: rtl/seq1101_code.sv
module seq1101_code
    import seq1101_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0,
    parameter int CODE_W  = ONE_HOT ? NUM_STATES : DENSE_W
) (
    input  prog_e             st_in,
    output logic [CODE_W-1:0] code_out,
    input  logic [CODE_W-1:0] code_in,
    output prog_e             st_out
);

    generate
        if (ONE_HOT) begin : g_onehot
            always_comb begin
                code_out = '0;
                code_out[st_in] = 1'b1;
            end
            always_comb begin
                st_out = ST_NONE;
                for (int i = 0; i < CODE_W; i++) begin
                    if (code_in[i]) st_out = prog_e'(i[DENSE_W-1:0]);
                end
            end
        end else begin : g_dense
            always_comb begin
                code_out = CODE_W'(st_in);
                st_out   = prog_e'(code_in[DENSE_W-1:0]);
            end
        end
    endgenerate

endmodule

// File: rtl/seq1101_advance.sv
module seq1101_advance
    import seq1101_pkg::*;
(
    input  prog_e cur_st,
    input  logic  bit_valid,
    input  logic  bit_in,
    output prog_e nxt_st
);

    always_comb begin
        nxt_st = cur_st;
        if (bit_valid) begin
            unique case (cur_st)
                ST_NONE:  nxt_st = bit_in ? ST_ONE   : ST_NONE;
                ST_ONE:   nxt_st = bit_in ? ST_TWO   : ST_NONE;
                ST_TWO:   nxt_st = bit_in ? ST_TWO   : ST_THREE;
                ST_THREE: nxt_st = bit_in ? ST_ONE   : ST_NONE;
                default:  nxt_st = ST_NONE;
            endcase
        end
    end

endmodule

// File: rtl/seq1101_flag.sv
module seq1101_flag
    import seq1101_pkg::*;
(
    input  prog_e cur_st,
    input  logic  rst,
    input  logic  bit_valid,
    input  logic  bit_in,
    output logic  hit
);

    always_comb begin
        hit = 1'b0;
        if (!rst && bit_valid && bit_in && (cur_st == ST_THREE)) hit = 1'b1;
    end

endmodule

// File: rtl/seq1101_watch.sv
module seq1101_watch
    import seq1101_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic match_out
);

    localparam int CODE_W = ONE_HOT ? NUM_STATES : DENSE_W;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } regs_t;

    regs_t regs_d, regs_q;
    prog_e cur_st, adv_st, load_st;
    logic [CODE_W-1:0] load_code;

    seq1101_code #(.ONE_HOT(ONE_HOT), .CODE_W(CODE_W)) u_code (
        .st_in    (load_st),
        .code_out (load_code),
        .code_in  (regs_q.code),
        .st_out   (cur_st)
    );

    seq1101_advance u_adv (
        .cur_st    (cur_st),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .nxt_st    (adv_st)
    );

    seq1101_flag u_flag (
        .cur_st    (cur_st),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .hit       (match_out)
    );

    always_comb begin
        load_st     = rst ? ST_NONE : adv_st;
        regs_d      = regs_q;
        regs_d.code = load_code;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

endmodule

// File: rtl/seq1101_watch_chk.sv
module seq1101_watch_chk
    import seq1101_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  bit_valid,
    input logic  bit_in,
    input logic  match_out,
    input prog_e cur_st
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cur_st == ST_NONE));

    // R2
    hit_needs_one_chk: assert property (@(posedge clk) disable iff (rst)
        match_out |-> (bit_valid && bit_in));

    // R3
    overlap_restart_chk: assert property (@(posedge clk) disable iff (rst)
        match_out |=> (cur_st == ST_ONE));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(cur_st));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |-> !match_out);

    // R6
    run_of_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_st == ST_TWO && bit_valid && bit_in) |=> (cur_st == ST_TWO));

endmodule

bind seq1101_watch seq1101_watch_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .match_out (match_out),
    .cur_st    (cur_st)
);

// File: tb/seq1101_watch_test.sv
`timescale 1ns/1ps
module seq1101_watch_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic match_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    seq1101_watch uut (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .match_out (match_out)
    );

    // {valid, bit, expected flag, requirement number}
    localparam int NVEC = 24;
    localparam logic [6:0] VEC [0:NVEC-1] = '{
        {3'b110, 4'd2}, {3'b110, 4'd2}, {3'b100, 4'd2}, {3'b111, 4'd2},  // R2: 1101
        {3'b110, 4'd3}, {3'b100, 4'd3}, {3'b111, 4'd3},                  // R3: overlap hit
        {3'b110, 4'd6}, {3'b110, 4'd6}, {3'b100, 4'd6},                  // R6: 111 then 0
        {3'b010, 4'd5}, {3'b000, 4'd4}, {3'b111, 4'd4},                  // R5 idle, R4 resume
        {3'b100, 4'd8}, {3'b110, 4'd8}, {3'b100, 4'd8},                  // R8: 1,0 drops
        {3'b110, 4'd7}, {3'b110, 4'd7}, {3'b100, 4'd7}, {3'b100, 4'd7},  // R7: 1100
        {3'b110, 4'd7}, {3'b110, 4'd7}, {3'b100, 4'd7}, {3'b111, 4'd7}
    };

    task automatic check(input logic got, input logic exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: match_out=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic b);
        @(negedge clk);
        bit_valid = v;
        bit_in    = b;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [2:0]  hist;
        logic [15:0] lfsr;
        logic        v, b, e;

        // R1: flag is quiet under reset
        drive(1'b1, 1'b1);
        check(match_out, 1'b0, "R1 reset quiet");
        do_reset();

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][6], VEC[i][5]);
            check(match_out, VEC[i][4], $sformatf("R%0d table step %0d", VEC[i][3:0], i));
        end

        // R1: history before reset is discarded
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        bit_valid = 1'b1;
        bit_in = 1'b1;
        #1;
        check(match_out, 1'b0, "R1 flag low during reset");
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(match_out, 1'b0, "R1 no hit after reset");
        drive(1'b1, 1'b1);
        check(match_out, 1'b0, "R1 second bit");
        drive(1'b1, 1'b0);
        check(match_out, 1'b0, "R1 third bit");
        drive(1'b1, 1'b1);
        check(match_out, 1'b1, "R1 fresh 1101 after reset");

        // R2 R3 R4 R5: long stream against a three-bit history reference
        do_reset();
        hist = 3'b000;
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            v = lfsr[0] | lfsr[3];
            b = lfsr[5] | lfsr[9];
            e = v && b && (hist == 3'b110);
            drive(v, b);
            check(match_out, e, "R2 stream vs history model");
            if (v) hist = {hist[1:0], b};
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule